// File: doc/BRIEF.md
# Bus Turnaround Idle Timer

This block sits in the host side of a serial bus controller. It decides when the host may begin its next packet after a transaction that may have failed. It watches two strobes from the line receiver: one for a line transition and one for end-of-packet. It also receives a clock-enable pulse that marks each bit time. The block counts consecutive bit times with no bus activity. Once the bus has been quiet for a full idle window, it raises a bus-free flag.

The counter restarts on every line transition, not only on end-of-packet. Suppose an end-of-packet is detected too early while the target is still driving. The host then keeps waiting until the real end-of-packet, and after that for a full quiet window. This window is sized to outlast the target's own response timeout, so the target sees the transfer as failed before the host speaks again.

A transmit request from the host is held while the bus is not free. It is granted in the first cycle in which the bus is free. A grant starts a new busy period.

Top module: `bus_turnaround_timer`

## Requirements
- R1: After reset, `bus_free_o` is 0 and `tx_grant_o` is 0. `bus_free_o` stays 0 until IDLE_BITS (default 16) bit-time pulses have been counted.
- R2: The idle count advances only in cycles where `bit_en_i` is 1. Once the count reaches IDLE_BITS it saturates, and `bus_free_o` stays 1 under further pulses.
- R3: In any cycle with `line_xtn_i` or `eop_i` high, `bus_free_o` is 0 in that same cycle. The idle count restarts from zero, so IDLE_BITS further pulses are needed before the bus is free again.
- R4: While transitions keep arriving at intervals shorter than IDLE_BITS bit times, `bus_free_o` never rises, even after an end-of-packet strobe. It rises IDLE_BITS pulses after the last strobe.
- R5: A request on `tx_req_i` seen while `bus_free_o` is 0 is remembered. It produces a single-cycle `tx_grant_o` in the first cycle in which `bus_free_o` is 1, and the request line need not still be high.
- R6: A request seen while `bus_free_o` is 1 is granted in the same cycle. `tx_grant_o` is never 1 while `bus_free_o` is 0.
- R7: After a grant, `bus_free_o` is 0 from the next cycle until a new idle window of IDLE_BITS pulses completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle pulse per bit time |
| line_xtn_i | input | 1 | Line transition seen this cycle |
| eop_i | input | 1 | End-of-packet detected this cycle |
| tx_req_i | input | 1 | Host asks to start a packet |
| bus_free_o | output | 1 | Bus quiet for a full idle window |
| tx_grant_o | output | 1 | One-cycle permission to start transmitting |

## Verification
The idle window is driven in three ways: with a pulse every cycle, with gaps in the pulses, and past saturation. These show whether counting depends on the enable and whether the count stops at the terminal value. Restart is tried in two ways: with single transition strobes and end-of-packet strobes while the bus is free, and with a train of transitions that follows a premature end-of-packet. The train separates a timer that restarts on any activity from one that restarts only at end-of-packet. Requests are issued in three situations: while the bus is busy, while it is free, and in the same cycle as a strobe. These separate a held request from an immediate grant and from a grant that was wrongly allowed.

// File: rtl/bus_turnaround_pkg.sv
package bus_turnaround_pkg;
  localparam int unsigned IdleBitsDef = 16;
endpackage

// File: rtl/idle_bit_counter.sv
module idle_bit_counter #(
  parameter int unsigned IDLE_BITS = 16,
  localparam int unsigned CW = $clog2(IDLE_BITS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic restart_i,
  output logic full_o
);
  logic [CW-1:0] cnt_q;
  localparam logic [CW-1:0] Term = CW'(IDLE_BITS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (restart_i)                 cnt_q <= '0;
    else if (bit_en_i && cnt_q != Term) cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == Term);

  // R2
  hold_no_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_en_i && !restart_i) |=> $stable(cnt_q));
  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= Term);
  // R3
  restart_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/tx_request_hold.sv
module tx_request_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic free_i,
  output logic grant_o
);
  logic pend_q;

  assign grant_o = (req_i | pend_q) & free_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (grant_o) pend_q <= 1'b0;
    else if (req_i)   pend_q <= 1'b1;
  end

  // R5
  pend_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && free_i) |-> grant_o);
  // R6
  grant_needs_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> free_i);
endmodule

// File: rtl/bus_turnaround_timer.sv
module bus_turnaround_timer #(
  parameter int unsigned IDLE_BITS = bus_turnaround_pkg::IdleBitsDef
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic line_xtn_i,
  input  logic eop_i,
  input  logic tx_req_i,
  output logic bus_free_o,
  output logic tx_grant_o
);
  logic activity;
  logic full;
  logic restart;

  assign activity   = line_xtn_i | eop_i;
  // strobe masks the flag in its own cycle
  assign bus_free_o = full & ~activity;
  assign restart    = activity | tx_grant_o;

  idle_bit_counter #(.IDLE_BITS(IDLE_BITS)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (bit_en_i),
    .restart_i (restart),
    .full_o    (full)
  );

  tx_request_hold u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (tx_req_i),
    .free_i  (bus_free_o),
    .grant_o (tx_grant_o)
  );

  // R3
  strobe_drops_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_xtn_i || eop_i) |-> !bus_free_o);
  // R7
  grant_then_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_grant_o |=> !bus_free_o);
  // R4
  activity_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activity |=> !bus_free_o);
endmodule

// File: tb/bus_turnaround_timer_tb_top.sv
module bus_turnaround_timer_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_en_i = 1'b0, line_xtn_i = 1'b0, eop_i = 1'b0, tx_req_i = 1'b0;
  logic bus_free_o, tx_grant_o;
  logic free_s, grant_s;
  int n_chk = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  bus_turnaround_timer dut_i (.*);

  task automatic drive(input logic en, input logic xtn, input logic eop, input logic req);
    @(negedge clk_i);
    bit_en_i = en; line_xtn_i = xtn; eop_i = eop; tx_req_i = req;
    #1;
    free_s = bus_free_o; grant_s = tx_grant_o;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) drive(1, 0, 0, 0);
  endtask

  task automatic t_reset();
    drive(0, 0, 0, 0);
    chk("R1 free after reset", free_s, 1'b0);
    chk("R1 grant after reset", grant_s, 1'b0);
    pulses(15);
    drive(0, 0, 0, 0);
    chk("R1 free after 15 pulses", free_s, 1'b0);
    pulses(1);
    drive(0, 0, 0, 0);
    chk("R1 free after 16 pulses", free_s, 1'b1);
  endtask

  task automatic t_gaps_sat();
    drive(0, 1, 0, 0);
    chk("R3 free dropped by transition", free_s, 1'b0);
    for (int i = 0; i < 15; i++) begin
      drive(1, 0, 0, 0);
      drive(0, 0, 0, 0);
      drive(0, 0, 0, 0);
    end
    for (int i = 0; i < 10; i++) drive(0, 0, 0, 0);
    chk("R2 no count without enable", free_s, 1'b0);
    pulses(1);
    drive(0, 0, 0, 0);
    chk("R2 free after 16 gapped pulses", free_s, 1'b1);
    pulses(40);
    drive(0, 0, 0, 0);
    chk("R2 free holds at saturation", free_s, 1'b1);
  endtask

  task automatic t_eop_restart();
    drive(1, 0, 1, 0);
    chk("R3 free dropped by eop", free_s, 1'b0);
    pulses(15);
    drive(0, 0, 0, 0);
    chk("R3 not free 15 after eop", free_s, 1'b0);
    pulses(1);
    drive(0, 0, 0, 0);
    chk("R3 free 16 after eop", free_s, 1'b1);
  endtask

  task automatic t_early_eop();
    logic seen = 1'b0;
    drive(1, 0, 1, 0);
    for (int k = 0; k < 6; k++) begin
      pulses(10);
      if (free_s) seen = 1'b1;
      drive(1, 1, 0, 0);
    end
    chk("R4 free never rose during traffic", seen, 1'b0);
    pulses(15);
    drive(0, 0, 0, 0);
    chk("R4 not free 15 after last transition", free_s, 1'b0);
    pulses(1);
    drive(0, 0, 0, 0);
    chk("R4 free 16 after last transition", free_s, 1'b1);
  endtask

  task automatic t_grant_free();
    drive(0, 0, 0, 1);
    chk("R6 immediate grant", grant_s, 1'b1);
    drive(0, 0, 0, 0);
    chk("R7 busy after grant", free_s, 1'b0);
    chk("R7 grant is one cycle", grant_s, 1'b0);
    pulses(15);
    drive(0, 0, 0, 0);
    chk("R7 not free 15 after grant", free_s, 1'b0);
    pulses(1);
    drive(0, 0, 0, 0);
    chk("R7 free 16 after grant", free_s, 1'b1);
  endtask

  task automatic t_pending();
    drive(0, 1, 0, 1);
    chk("R6 no grant on strobe cycle", grant_s, 1'b0);
    pulses(15);
    chk("R5 no grant while busy", grant_s, 1'b0);
    pulses(1);
    drive(0, 0, 0, 0);
    chk("R5 pending granted when free", grant_s, 1'b1);
    drive(0, 0, 0, 0);
    chk("R5 grant single cycle", grant_s, 1'b0);
    chk("R7 busy after pending grant", free_s, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_gaps_sat();
        t_eop_restart();
        t_early_eop();
        t_grant_free();
        t_pending();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule